// File: doc/BRIEF.md
# Black-Level Clamp Servo

This block keeps the dark level of a line-scanned image sensor front end at a programmed value. Once per pixel clock it receives a converter sample, a black-pixel window strobe, an 8-bit target level, a loop-off control and the strobe's active polarity. It drives an 8-bit code to an offset DAC that sits ahead of the converter.

While the window is active, the block adds the difference between the target and the sample to a fractional accumulator. The upper eight bits of that accumulator form the DAC code. The extra fraction bits act as a first-order low-pass filter with a gain of 1/2^K, so pixel noise moves the code slowly. Outside the window the code is held, so a correction found on the dark pixels of one line is carried across the active pixels to the next line.

When the loop is switched off, the code follows the target level directly and acts as a fixed programmable offset. A later enable starts integrating from that value. The target has 256 steps. With a 12-bit converter one step is one output LSB. With a 10-bit converter one step is a quarter LSB.

Top module: `black_clamp_servo`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets the accumulator to 128·2^K, so dac_code_o reads 128 from the following cycle.
- R2: While the loop is on and the window is inactive, dac_code_o holds its value whatever the sample and target are.
- R3: The window is active when win_i equals win_pol_i: win_pol_i = 1 makes a high strobe active, and win_pol_i = 0 makes a low strobe active.
- R4: On each active pixel with the loop on, the accumulator (8+K bits wide, K = 4 by default) adds the signed error target − sample, with the sample expressed in target steps. dac_code_o equals the accumulator shifted right by K, one cycle after the edge.
- R5: The accumulator saturates at 0 and at 2^(8+K) − 1, so dac_code_o never wraps: it stays at 255 under a persistent positive error and at 0 under a persistent negative error.
- R6: With loop_off_i high, the accumulator loads target·2^K on every edge, whatever the window, so dac_code_o equals the target one cycle later. After loop_off_i falls, integration starts from that value.
- R7: With ADC_W = 10, the sample is scaled by 4 before the comparison, so a target of 128 balances a sample of 32. A sample of 31 adds +4 per active pixel.
- R8: In closed loop, with the converter modelled as sample = fixed offset + DAC code, repeated 20-pixel windows bring the sample to within ±1 LSB of the target. When the offset cannot be cancelled, the code settles at the rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | ADC_W | Converter output word, straight binary |
| win_i | input | 1 | Black-pixel window strobe |
| win_pol_i | input | 1 | Active level of the window strobe |
| target_i | input | 8 | Target black level in target steps |
| loop_off_i | input | 1 | 1 turns the loop into a static offset equal to target_i |
| dac_code_o | output | 8 | Correction code for the offset DAC |

## Verification
On every cycle, the assertions check the reset value, the hold outside the window, the direct tracking of the target while the loop is off, and that the code never moves against the sign of the error (which rules out wrapping at both rails). The bench scenarios are the only place that shows the exact accumulation arithmetic and the strobe polarity choice. They also show the quarter-LSB scaling of the 10-bit variant and that a closed loop with an injected offset settles within one LSB of the target.

// File: rtl/obc_pkg.sv
package obc_pkg;
    localparam int DAC_W = 8;
    localparam logic [DAC_W-1:0] RESET_CODE = 8'd128;
    localparam int TARGET_RES_BITS = 12;

    typedef enum logic {
        STROBE_LOW  = 1'b0,
        STROBE_HIGH = 1'b1
    } strobe_pol_e;
endpackage

// File: rtl/obc_window_qual.sv
module obc_window_qual
    import obc_pkg::*;
(
    input  logic win_i,
    input  logic win_pol_i,
    output logic active_o
);
    strobe_pol_e pol;

    always_comb begin
        pol      = strobe_pol_e'(win_pol_i);
        active_o = (pol == STROBE_HIGH) ? win_i : ~win_i;
    end
endmodule

// File: rtl/obc_error_calc.sv
module obc_error_calc
    import obc_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int FRAC  = 0,
    localparam int UW   = ADC_W + FRAC,
    localparam int EW   = UW + 1
) (
    input  logic [ADC_W-1:0]    sample_i,
    input  logic [DAC_W-1:0]    target_i,
    output logic signed [EW-1:0] err_o
);
    logic [UW-1:0] units;

    generate
        if (FRAC > 0) begin : g_fine
            always_comb units = {sample_i, {FRAC{1'b0}}};
        end else begin : g_direct
            always_comb units = sample_i;
        end
    endgenerate

    always_comb begin
        err_o = $signed({1'b0, UW'(target_i)}) - $signed({1'b0, units});
    end
endmodule

// File: rtl/obc_integrator.sv
module obc_integrator
    import obc_pkg::*;
#(
    parameter int K  = 4,
    parameter int EW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active_i,
    input  logic                 off_i,
    input  logic [DAC_W-1:0]     target_i,
    input  logic signed [EW-1:0] err_i,
    output logic [DAC_W-1:0]     code_o
);
    localparam int AW      = DAC_W + K;
    localparam int SW      = ((AW > EW) ? AW : EW) + 2;
    localparam int ACC_TOP = (1 << AW) - 1;
    localparam logic [AW-1:0] ACC_RST = {RESET_CODE, {K{1'b0}}};

    typedef struct packed {
        logic [AW-1:0] acc;
    } integ_t;

    integ_t s_q, s_d;
    logic signed [SW-1:0] sum_d;

    always_comb begin
        s_d   = s_q;
        sum_d = $signed({{(SW-AW){1'b0}}, s_q.acc})
              + $signed({{(SW-EW){err_i[EW-1]}}, err_i});
        if (off_i) begin
            s_d.acc = {target_i, {K{1'b0}}};
        end else if (active_i) begin
            if (sum_d < 0) begin
                s_d.acc = '0;
            end else if (sum_d > ACC_TOP) begin
                s_d.acc = '1;
            end else begin
                s_d.acc = sum_d[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.acc <= ACC_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.acc[AW-1:K];

    // R1: reset value appears on the code
    a_r1_reset_code: assert property (@(posedge clk)
        !rst_n |=> code_o == RESET_CODE);

    // R2: hold outside the window
    a_r2_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !off_i) |=> $stable(code_o));

    // R4/R5: positive error never lowers the code (no wrap at the top)
    a_r5_rise_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !off_i && err_i > 0) |=> code_o >= $past(code_o));

    // R4/R5: negative error never raises the code (no wrap at zero)
    a_r5_fall_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !off_i && err_i < 0) |=> code_o <= $past(code_o));

    // R6: static offset follows the target
    a_r6_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> code_o == $past(target_i));
endmodule

// File: rtl/black_clamp_servo.sv
module black_clamp_servo
    import obc_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int K     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] sample_i,
    input  logic             win_i,
    input  logic             win_pol_i,
    input  logic [7:0]       target_i,
    input  logic             loop_off_i,
    output logic [7:0]       dac_code_o
);
    localparam int FRAC = (ADC_W < TARGET_RES_BITS) ? (TARGET_RES_BITS - ADC_W) : 0;
    localparam int EW   = ADC_W + FRAC + 1;

    logic                 active;
    logic signed [EW-1:0] err;

    obc_window_qual u_win (
        .win_i     (win_i),
        .win_pol_i (win_pol_i),
        .active_o  (active)
    );

    obc_error_calc #(.ADC_W(ADC_W), .FRAC(FRAC)) u_err (
        .sample_i (sample_i),
        .target_i (target_i),
        .err_o    (err)
    );

    obc_integrator #(.K(K), .EW(EW)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .off_i    (loop_off_i),
        .target_i (target_i),
        .err_i    (err),
        .code_o   (dac_code_o)
    );
endmodule

// File: tb/tb_black_clamp_servo.sv
module tb_black_clamp_servo;
    localparam int CLK_PERIOD = 10;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample = '0;
    logic [9:0]  sample10 = '0;
    logic        win = 1'b0;
    logic        pol = 1'b1;
    logic [7:0]  target = 8'd128;
    logic        loop_off = 1'b0;
    logic [7:0]  code;
    logic [7:0]  code10;

    int checks = 0;
    int failures = 0;
    int m_acc = 128 * 16;

    int    q_exp[$];
    string q_tag[$];

    bit    c_rst = 1'b0;
    bit    c_off = 1'b0;
    bit    c_pol = 1'b1;
    int    c_tgt = 128;
    int    c_s10 = 0;
    int    base = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    black_clamp_servo #(.ADC_W(12), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .win_i(win),
        .win_pol_i(pol), .target_i(target), .loop_off_i(loop_off),
        .dac_code_o(code)
    );

    black_clamp_servo #(.ADC_W(10), .K(K)) dut10 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample10), .win_i(win),
        .win_pol_i(pol), .target_i(target), .loop_off_i(loop_off),
        .dac_code_o(code10)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one pixel per call, pushes the expected code after the next edge
    task automatic px(input int smp, input bit w, input string tag);
        bit act;
        @(negedge clk);
        rst_n    = c_rst;
        loop_off = c_off;
        pol      = c_pol;
        target   = 8'(c_tgt);
        sample   = 12'(smp);
        sample10 = 10'(c_s10);
        win      = w;
        act = (w == c_pol);
        if (!c_rst) m_acc = 128 << K;
        else if (c_off) m_acc = c_tgt << K;
        else if (act) begin
            m_acc = m_acc + c_tgt - smp;
            if (m_acc < 0) m_acc = 0;
            if (m_acc > 4095) m_acc = 4095;
        end
        q_exp.push_back(m_acc >> K);
        q_tag.push_back(tag);
    endtask

    task automatic px_loop(input bit w, input string tag);
        px(base + (m_acc >> K), w, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                int e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, int'(code), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset
        c_rst = 0; c_pol = 1; c_tgt = 128;
        for (int i = 0; i < 3; i++) px(0, 0, "R1 reset");
        c_rst = 1;
        // R2: idle outside window, target moved
        c_tgt = 10;
        for (int i = 0; i < 5; i++) px(3000, 0, "R2 hold");
        c_tgt = 128;
        // R4: below target raises, above lowers
        for (int i = 0; i < 4; i++) px(120, 1, "R4 rise");
        for (int i = 0; i < 6; i++) px(140, 1, "R4 fall");
        for (int i = 0; i < 3; i++) px(0, 0, "R2 hold after");
        // R3: active-low strobe
        c_pol = 0;
        for (int i = 0; i < 4; i++) px(0, 1, "R3 low-pol high strobe ignored");
        for (int i = 0; i < 4; i++) px(100, 0, "R3 low-pol low strobe active");
        c_pol = 1;
        // R5: top rail
        c_tgt = 255;
        for (int i = 0; i < 40; i++) px(0, 1, "R5 top sat");
        // R5: bottom rail
        c_tgt = 0;
        for (int i = 0; i < 40; i++) px(4095, 1, "R5 bottom sat");
        // R6: static offset, window ignored
        c_off = 1; c_tgt = 77;
        for (int i = 0; i < 3; i++) px(0, 1, "R6 off win");
        for (int i = 0; i < 3; i++) px(4095, 0, "R6 off idle");
        c_off = 0;
        for (int i = 0; i < 3; i++) px(45, 1, "R6 resume");
        // R7: 10-bit scaling
        c_rst = 0; c_tgt = 128;
        px(0, 0, "R7 reset");
        c_rst = 1; c_s10 = 32;
        for (int i = 0; i < 4; i++) px(128, 1, "R7 main");
        @(posedge clk); #1;
        check("R7 balance at 32", int'(code10), 128);
        c_s10 = 31;
        for (int i = 0; i < 4; i++) px(128, 1, "R7 main");
        @(posedge clk); #1;
        check("R7 step at 31", int'(code10), 129);
        // R8: closed loop, cancellable offset
        c_rst = 0; px(0, 0, "R8 reset"); c_rst = 1;
        base = 40; c_tgt = 128;
        for (int ln = 0; ln < 12; ln++) begin
            for (int i = 0; i < 20; i++) px_loop(1, "R8 converge");
            for (int i = 0; i < 30; i++) px_loop(0, "R8 converge hold");
        end
        @(posedge clk); #1;
        begin
            int d;
            d = base + int'(code) - c_tgt;
            if (d < 0) d = -d;
            check("R8 within 1 LSB", (d <= 1) ? 1 : 0, 1);
        end
        // R8: offset too large, code rests at zero
        base = 200;
        for (int ln = 0; ln < 6; ln++) begin
            for (int i = 0; i < 20; i++) px_loop(1, "R8 rail");
            for (int i = 0; i < 10; i++) px_loop(0, "R8 rail hold");
        end
        @(posedge clk); #1;
        check("R8 rail code", int'(code), 0);
        repeat (3) @(posedge clk);
        summary();
        $finish;
    end
endmodule